// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This engine turns a 32-bit address issued by a bus-mastering device into a 36-bit physical address. For each request it computes where the matching page-table entry lives, reads that one 32-bit entry through a memory read port, and checks the entry's valid and writable flags against the request direction. A good entry yields the physical address and a permission code. A bad entry yields a fault response, together with a one-cycle capture strobe that carries a fixed status word and the faulting page address. A fault register bank uses that strobe to latch the fault and raise its interrupt.

The engine accepts one request at a time. Its state sequence is idle, then fetch, then respond. The fetch state waits for the memory port's response-valid, so the read latency can be anything from zero cycles upward. When translation is switched off, the request address comes back unchanged and no memory access is made. The register bank supplies the table base, the window start and the enable bit. The engine samples all three when it accepts a request.

Top module: `iopt_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `req_ready` is 1 and `mem_req`, `rsp_valid` and `flt_strobe` are 0. This holds even if the reset arrives during a fetch.
- R2: `req_ready` is high only in the idle state. A request is accepted on the first edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the edge after the response. Changes to the request inputs and the register-bank inputs after acceptance do not affect that response.
- R3: The entry address on `mem_addr` is `({4'b0,tbl_base} << 4) + {4'b0, ((page & ~win_start) >> 10) & ~3}`, truncated to 36 bits. Here `page` is `req_addr` with bits [11:0] cleared.
- R4: `mem_rsp_data` carries the entry's bytes in address order: the byte at the entry address is in bits [7:0]. The engine reads that byte as entry bits [31:24], so the entry is big-endian.
- R5: For a granted translation, `rsp_paddr` = `{entry[31:8], req_addr[11:0]}`.
- R6: An entry with the valid bit (bit 1) clear gives a fault response, for both reads and writes.
- R7: A write whose entry has the writable bit (bit 2) clear gives a fault. A read of such an entry is granted.
- R8: `rsp_perm` is 2'b11 (read-write) when the granted entry has bit 2 set, 2'b01 (read-only) when it does not, and 2'b00 on a fault. On a fault, `rsp_paddr` is 0.
- R9: A fault response raises `flt_strobe` in the same cycle as `rsp_valid`. At that point `flt_status` is 32'hC0820000, with bit 18 also set (32'hC0860000) for a read, and `flt_addr` is the page address.
- R10: When `xlate_en` is 0 at acceptance, no memory read is made. `rsp_valid` rises in the cycle after acceptance, with `rsp_paddr` = `{4'b0, req_addr}`, `rsp_perm` = 2'b11 and no fault.
- R11: `mem_req` stays high with a constant `mem_addr` until `mem_rsp_valid` is seen. `rsp_valid` follows in the next cycle, so a read latency of L cycles makes the response arrive L+2 cycles after acceptance.
- R12: Entry bits 7 (cacheable) and 0 (write-as-zero) do not affect the fault decision, the permission or the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlate_en | input | 1 | Translation enable from the register bank |
| tbl_base | input | 32 | Table base from the register bank; shifted left by 4 to form the table address |
| win_start | input | 32 | Window start; its set bits are removed from the page before indexing |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine is idle and will accept a request |
| req_addr | input | 32 | Device address to translate |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| mem_req | output | 1 | Entry read in progress |
| mem_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data is present on `mem_rsp_data` |
| mem_rsp_data | input | 32 | Entry bytes in address order |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault | output | 1 | Response is a fault |
| flt_strobe | output | 1 | Fault capture strobe for the register bank |
| flt_status | output | 32 | Fault status value to capture |
| flt_addr | output | 32 | Faulting page address to capture |

## Verification
The hardest condition to reach from the ports is a fetch that is still waiting on memory while something around it changes: the request inputs, the base and window inputs, or reset itself. The bench's memory model holds back `mem_rsp_valid` for a chosen number of cycles. While the engine waits, some table rows keep `req_valid` high and drive inverted address, direction, base and window values; the result must still match the values sampled at acceptance. A directed case sets a long latency and pulls reset in the middle of the wait, then runs a normal translation to show that the engine recovers. The base value of all ones forces a carry out of 36 bits when the entry address is formed.

// File: rtl/iopt_pkg.sv
// Shared constants and types for the I/O page table translation engine.
// Assumes 32-bit entries with a 24-bit page number above bit 8.
package iopt_pkg;

    localparam int unsigned VA_W       = 32;
    localparam int unsigned PA_W       = 36;
    localparam int unsigned PTE_W      = 32;
    localparam int unsigned PAGE_BITS  = 12;
    localparam int unsigned BASE_SHIFT = 4;
    localparam int unsigned PPN_LSB    = 8;

    localparam int unsigned PTE_VALID_BIT = 1;
    localparam int unsigned PTE_WRITE_BIT = 2;

    localparam logic [31:0] FLT_STATUS_BASE = 32'hC082_0000;
    localparam logic [31:0] FLT_STATUS_READ = 32'h0004_0000;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } xl_state_e;

endpackage

// File: rtl/iopt_ent_addr.sv
// Entry address former: clears the page offset, removes the window bits,
// scales the page number to a word index and adds the shifted table base.
// Purely combinational; the result wraps at PW bits.
module iopt_ent_addr
    import iopt_pkg::*;
#(
    parameter int unsigned VW  = VA_W,
    parameter int unsigned PW  = PA_W,
    parameter int unsigned PGB = PAGE_BITS,
    parameter int unsigned BSH = BASE_SHIFT
) (
    input  logic [VW-1:0] va,
    input  logic [VW-1:0] base,
    input  logic [VW-1:0] win,
    output logic [VW-1:0] page,
    output logic [PW-1:0] ent_addr
);

    localparam int unsigned IDX_SHIFT = PGB - 2;
    localparam int unsigned EXT       = PW - VW;

    logic [VW-1:0] masked;
    logic [VW-1:0] idx;

    // Form the page, the windowed word index and the final entry address.
    always_comb begin
        page     = {va[VW-1:PGB], {PGB{1'b0}}};
        masked   = page & ~win;
        idx      = (masked >> IDX_SHIFT) & ~VW'(3);
        ent_addr = ({{EXT{1'b0}}, base} << BSH) + {{EXT{1'b0}}, idx};
    end

endmodule

// File: rtl/iopt_ent_check.sv
// Entry decoder and checker: restores the entry's byte order, tests the
// valid and writable flags against the access direction, and produces the
// physical address, the permission and the fault status word.
// Assumes PTEW is a multiple of 8. Purely combinational.
module iopt_ent_check
    import iopt_pkg::*;
#(
    parameter int unsigned PTEW    = PTE_W,
    parameter int unsigned PW      = PA_W,
    parameter int unsigned PGB     = PAGE_BITS,
    parameter int unsigned PLSB    = PPN_LSB,
    parameter bit          BIG_END = 1'b1
) (
    input  logic [PTEW-1:0] mem_word,
    input  logic            is_write,
    input  logic [PGB-1:0]  offset,
    output logic [PW-1:0]   paddr,
    output perm_e           perm,
    output logic            fault,
    output logic [31:0]     status
);

    localparam int unsigned NBYTES = PTEW / 8;
    localparam logic [PTEW-1:0] PPN_MASK = {{(PTEW-PLSB){1'b1}}, {PLSB{1'b0}}};
    localparam logic [PTEW-1:0] V_MASK   = PTEW'(1 << PTE_VALID_BIT);
    localparam logic [PTEW-1:0] W_MASK   = PTEW'(1 << PTE_WRITE_BIT);

    logic [PTEW-1:0] entry;
    logic            valid_f;
    logic            write_f;
    logic [PW-1:0]   paddr_raw;

    // Byte order selection: the lowest-addressed byte becomes the top byte.
    generate
        if (BIG_END) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign entry[8*b +: 8] = mem_word[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_keep
            assign entry = mem_word;
        end
    endgenerate

    // Flag test, page-number placement and fault word.
    always_comb begin
        valid_f   = |(entry & V_MASK);
        write_f   = |(entry & W_MASK);
        paddr_raw = (PW'(entry & PPN_MASK) << (PGB - PLSB)) + PW'(offset);
        fault     = !valid_f || (is_write && !write_f);
        if (fault) begin
            perm   = PERM_NONE;
            paddr  = '0;
            status = FLT_STATUS_BASE | (is_write ? 32'h0 : FLT_STATUS_READ);
        end else begin
            perm   = write_f ? PERM_RW : PERM_RO;
            paddr  = paddr_raw;
            status = 32'h0;
        end
    end

endmodule

// File: rtl/iopt_ctrl.sv
// Request sequencer: idle -> fetch -> respond, or idle -> respond when
// translation is off. It captures the request and the entry address at
// acceptance and registers the result for a one-cycle response.
// Assumes the memory side answers only while mem_req is high.
module iopt_ctrl
    import iopt_pkg::*;
#(
    parameter int unsigned VW  = VA_W,
    parameter int unsigned PW  = PA_W,
    parameter int unsigned PGB = PAGE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VW-1:0]   req_addr,
    input  logic            req_write,
    input  logic            xlate_en,
    input  logic [PW-1:0]   ent_addr_in,
    input  logic [VW-1:0]   page_in,
    input  logic            mem_rsp_valid,
    input  logic [PW-1:0]   chk_paddr,
    input  perm_e           chk_perm,
    input  logic            chk_fault,
    input  logic [31:0]     chk_status,
    output logic            req_ready,
    output logic            mem_req,
    output logic [PW-1:0]   mem_addr,
    output logic            wr_q,
    output logic [PGB-1:0]  off_q,
    output logic            rsp_valid,
    output logic [PW-1:0]   rsp_paddr,
    output logic [1:0]      rsp_perm,
    output logic            rsp_fault,
    output logic            flt_strobe,
    output logic [31:0]     flt_status,
    output logic [VW-1:0]   flt_addr
);

    xl_state_e      state_q;
    logic           accept;
    logic           fetch_done;
    logic [VW-1:0]  page_q;
    logic [PW-1:0]  maddr_q;
    logic [PW-1:0]  paddr_q;
    perm_e          perm_q;
    logic           fault_q;
    logic [31:0]    status_q;
    logic [VW-1:0]  faddr_q;

    // Handshake and completion events.
    always_comb begin
        accept     = req_valid && (state_q == ST_IDLE);
        fetch_done = mem_rsp_valid && (state_q == ST_FETCH);
    end

    // State sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (req_valid) state_q <= xlate_en ? ST_FETCH : ST_RESP;
                ST_FETCH: if (mem_rsp_valid) state_q <= ST_RESP;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maddr_q <= '0;
            page_q  <= '0;
            off_q   <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            maddr_q <= ent_addr_in;
            page_q  <= page_in;
            off_q   <= req_addr[PGB-1:0];
            wr_q    <= req_write;
        end
    end

    // Result capture: pass-through at acceptance, checked entry at fetch end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q  <= '0;
            perm_q   <= PERM_NONE;
            fault_q  <= 1'b0;
            status_q <= '0;
            faddr_q  <= '0;
        end else if (accept && !xlate_en) begin
            paddr_q  <= PW'(req_addr);
            perm_q   <= PERM_RW;
            fault_q  <= 1'b0;
            status_q <= '0;
            faddr_q  <= '0;
        end else if (fetch_done) begin
            paddr_q  <= chk_paddr;
            perm_q   <= chk_perm;
            fault_q  <= chk_fault;
            status_q <= chk_status;
            faddr_q  <= chk_fault ? page_q : '0;
        end
    end

    // Output decode from the registered state and result.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_FETCH);
        mem_addr   = maddr_q;
        rsp_valid  = (state_q == ST_RESP);
        rsp_paddr  = paddr_q;
        rsp_perm   = perm_q;
        rsp_fault  = fault_q;
        flt_strobe = (state_q == ST_RESP) && fault_q;
        flt_status = status_q;
        flt_addr   = faddr_q;
    end

endmodule

// File: rtl/iopt_xlate.sv
// Top of the I/O page table translation engine. Connects the entry address
// former, the sequencer and the entry checker. Base, window and enable are
// sampled when a request is accepted; one request is in flight at a time.
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int unsigned VA_BITS = VA_W,
    parameter int unsigned PA_BITS = PA_W,
    parameter int unsigned PT_BITS = PTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xlate_en,
    input  logic [VA_BITS-1:0] tbl_base,
    input  logic [VA_BITS-1:0] win_start,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_BITS-1:0] req_addr,
    input  logic               req_write,
    output logic               mem_req,
    output logic [PA_BITS-1:0] mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [PT_BITS-1:0] mem_rsp_data,
    output logic               rsp_valid,
    output logic [PA_BITS-1:0] rsp_paddr,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault,
    output logic               flt_strobe,
    output logic [31:0]        flt_status,
    output logic [VA_BITS-1:0] flt_addr
);

    logic [VA_BITS-1:0]   page_w;
    logic [PA_BITS-1:0]   ent_addr_w;
    logic                 wr_w;
    logic [PAGE_BITS-1:0] off_w;
    logic [PA_BITS-1:0]   chk_paddr_w;
    perm_e                chk_perm_w;
    logic                 chk_fault_w;
    logic [31:0]          chk_status_w;

    iopt_ent_addr #(
        .VW (VA_BITS),
        .PW (PA_BITS),
        .PGB(PAGE_BITS),
        .BSH(BASE_SHIFT)
    ) addr_i (
        .va      (req_addr),
        .base    (tbl_base),
        .win     (win_start),
        .page    (page_w),
        .ent_addr(ent_addr_w)
    );

    iopt_ctrl #(
        .VW (VA_BITS),
        .PW (PA_BITS),
        .PGB(PAGE_BITS)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .xlate_en     (xlate_en),
        .ent_addr_in  (ent_addr_w),
        .page_in      (page_w),
        .mem_rsp_valid(mem_rsp_valid),
        .chk_paddr    (chk_paddr_w),
        .chk_perm     (chk_perm_w),
        .chk_fault    (chk_fault_w),
        .chk_status   (chk_status_w),
        .req_ready    (req_ready),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .wr_q         (wr_w),
        .off_q        (off_w),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_perm     (rsp_perm),
        .rsp_fault    (rsp_fault),
        .flt_strobe   (flt_strobe),
        .flt_status   (flt_status),
        .flt_addr     (flt_addr)
    );

    iopt_ent_check #(
        .PTEW   (PT_BITS),
        .PW     (PA_BITS),
        .PGB    (PAGE_BITS),
        .PLSB   (PPN_LSB),
        .BIG_END(1'b1)
    ) check_i (
        .mem_word(mem_rsp_data),
        .is_write(wr_w),
        .offset  (off_w),
        .paddr   (chk_paddr_w),
        .perm    (chk_perm_w),
        .fault   (chk_fault_w),
        .status  (chk_status_w)
    );

endmodule

// File: rtl/iopt_xlate_chk.sv
// Protocol checker for the translation engine, attached by bind.
// Observes ports only.
module iopt_xlate_chk #(
    parameter int unsigned PW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xlate_en,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_req,
    input logic [PW-1:0] mem_addr,
    input logic          mem_rsp_valid,
    input logic          rsp_valid,
    input logic [1:0]    rsp_perm,
    input logic          rsp_fault,
    input logic          flt_strobe,
    input logic [31:0]   flt_status
);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // R2
    resp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R11
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp_valid) |=> (rsp_valid && !mem_req));

    // R10
    bypass_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlate_en) |=>
            (rsp_valid && !mem_req && !rsp_fault && rsp_perm == 2'b11));

    // R9
    fault_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_strobe |-> (rsp_valid && rsp_fault && rsp_perm == 2'b00 &&
                        (flt_status & 32'hFFFB_FFFF) == 32'hC082_0000));

    // R9
    fault_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> flt_strobe);

    // R8
    grant_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b01 || rsp_perm == 2'b11));

endmodule

bind iopt_xlate iopt_xlate_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .xlate_en     (xlate_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_valid    (rsp_valid),
    .rsp_perm     (rsp_perm),
    .rsp_fault    (rsp_fault),
    .flt_strobe   (flt_strobe),
    .flt_status   (flt_status)
);

// File: tb/iopt_xlate_tb_top.sv
`timescale 1ns/1ps
module iopt_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xlate_en;
    logic [31:0] tbl_base;
    logic [31:0] win_start;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        req_write;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'h0;
    logic        rsp_valid;
    logic [35:0] rsp_paddr;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;
    logic        flt_strobe;
    logic [31:0] flt_status;
    logic [31:0] flt_addr;

    always #4 clk = ~clk;

    iopt_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .tbl_base(tbl_base),
        .win_start(win_start), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .flt_strobe(flt_strobe), .flt_status(flt_status), .flt_addr(flt_addr)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Memory model state
    int          lat_cfg   = 0;
    logic [31:0] entry_cfg = 32'h0;
    int          wait_cnt  = 0;
    int          fetch_cnt = 0;
    logic [35:0] first_addr = '0;
    logic [35:0] seen_addr  = '0;
    bit          addr_moved = 0;

    localparam int NV = 13;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'hFF01_2345, 32'hFE7F_F008, 32'h8000_0FFF, 32'h8000_1000,
        32'hC123_4567, 32'hF0AB_C000, 32'h89AB_CDEF, 32'h0000_0000,
        32'h1234_5678, 32'hFFFF_F000, 32'h0000_A000, 32'h7FFF_FFFC,
        32'h00FF_F123};
    localparam logic V_WR [NV] = '{0,1,0,1,0,1,1,0,0,1,1,0,0};
    localparam logic V_EN [NV] = '{1,1,1,1,1,1,0,0,1,1,1,1,1};
    localparam logic [31:0] V_BASE [NV] = '{
        32'h0000_1000, 32'h07FF_FC00, 32'h0000_0000, 32'h0000_0000,
        32'h0040_0000, 32'h0000_0040, 32'h1111_1111, 32'h0000_0000,
        32'h0002_0000, 32'hFFFF_FFFF, 32'h0000_0100, 32'h0000_0200,
        32'h0000_0000};
    localparam logic [31:0] V_WIN [NV] = '{
        32'hFF00_0000, 32'hFE00_0000, 32'h8000_0000, 32'h8000_0000,
        32'hC000_0000, 32'hF000_0000, 32'h0000_0000, 32'h0000_0000,
        32'hFF00_0000, 32'hFF00_0000, 32'hFFFF_0000, 32'h0000_0000,
        32'hFE00_0000};
    localparam logic [31:0] V_ENTRY [NV] = '{
        32'h1234_5606, 32'hABCD_EF86, 32'h0000_0103, 32'h0000_0103,
        32'hFFFF_FF84, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
        32'h0200_0006, 32'hFEDC_BA06, 32'h0000_0004, 32'h0000_0001,
        32'hFFFF_FF82};
    localparam int V_LAT [NV] = '{0,3,1,2,5,0,0,0,2,1,0,4,0};
    localparam logic V_HOLD [NV] = '{0,1,0,0,0,0,0,0,1,0,0,0,0};

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirement text
    function automatic logic [35:0] ref_eaddr(logic [31:0] base, logic [31:0] win,
                                              logic [31:0] a);
        logic [31:0] pg;
        logic [35:0] b;
        pg = a & 32'hFFFF_F000;
        b  = {4'h0, base};
        return (b << 4) + {4'h0, ((pg & ~win) >> 10) & 32'hFFFF_FFFC};
    endfunction

    function automatic logic [31:0] to_mem(logic [31:0] e);
        return {e[7:0], e[15:8], e[23:16], e[31:24]};
    endfunction

    // Memory model: answers lat_cfg cycles after mem_req is first seen
    always @(negedge clk) begin
        if (mem_req && !mem_rsp_valid) begin
            if (wait_cnt == 0) first_addr = mem_addr;
            else if (mem_addr !== first_addr) addr_moved = 1;
            if (wait_cnt == lat_cfg) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = to_mem(entry_cfg);
                seen_addr     = mem_addr;
                fetch_cnt++;
            end else begin
                wait_cnt++;
            end
        end else begin
            mem_rsp_valid = 1'b0;
            wait_cnt      = 0;
        end
    end

    task automatic run_vec(input logic [31:0] a, input logic wr, input logic en,
                           input logic [31:0] base, input logic [31:0] win,
                           input logic [31:0] e, input int lat, input logic hold);
        int  cyc;
        int  f0;
        bit  got;
        bit  busy_bad;
        logic exp_fault;
        logic [1:0] exp_perm;
        logic [35:0] exp_pa;
        string pa_tag;
        string pm_tag;
        @(negedge clk);
        lat_cfg = lat; entry_cfg = e; xlate_en = en; tbl_base = base;
        win_start = win; req_addr = a; req_write = wr; req_valid = 1'b1;
        check("R2", "ready when idle", req_ready, 1);
        f0 = fetch_cnt; addr_moved = 0;
        @(posedge clk);
        cyc = 0; got = 0; busy_bad = 0;
        for (int k = 0; k < 300 && !got; k++) begin
            @(negedge clk);
            cyc++;
            if (hold) begin
                req_addr = ~a; req_write = ~wr; tbl_base = ~base;
                win_start = ~win; xlate_en = ~en;
            end else begin
                req_valid = 1'b0;
            end
            if (rsp_valid) got = 1;
            if (req_ready) busy_bad = 1;
        end
        req_valid = 1'b0;
        check("R2", "ready low while busy", busy_bad, 0);
        check("R11", "response cycle", cyc, en ? lat + 2 : 1);
        if (en) begin
            check("R3", "entry address", seen_addr, ref_eaddr(base, win, a));
            check("R11", "one fetch", fetch_cnt - f0, 1);
            check("R11", "address held", addr_moved, 0);
            exp_fault = !e[1] || (wr && !e[2]);
            exp_perm  = exp_fault ? 2'b00 : (e[2] ? 2'b11 : 2'b01);
            exp_pa    = exp_fault ? 36'h0 : {e[31:8], a[11:0]};
            pa_tag    = (e[7] || e[0]) ? "R4,R5,R12" : "R4,R5";
            pm_tag    = (e[7] || e[0]) ? "R8,R12" : "R8";
        end else begin
            check("R10", "no fetch", fetch_cnt - f0, 0);
            exp_fault = 0; exp_perm = 2'b11; exp_pa = {4'h0, a};
            pa_tag = "R10"; pm_tag = "R10";
        end
        check(!e[1] ? "R6" : "R7", "fault flag", rsp_fault, exp_fault);
        check(pm_tag, "permission", rsp_perm, exp_perm);
        check(pa_tag, "physical address", rsp_paddr, exp_pa);
        check("R9", "fault strobe", flt_strobe, exp_fault);
        if (exp_fault) begin
            check("R9", "fault status", flt_status,
                  wr ? 32'hC082_0000 : 32'hC086_0000);
            check("R9", "fault address", flt_addr, a & 32'hFFFF_F000);
        end
        @(negedge clk);
        check("R2", "idle after response", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; xlate_en = 1'b0; tbl_base = '0; win_start = '0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "ready in reset", req_ready, 1);
        check("R1", "mem_req in reset", mem_req, 0);
        check("R1", "rsp_valid in reset", rsp_valid, 0);
        check("R1", "flt_strobe in reset", flt_strobe, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_vec(V_ADDR[v], V_WR[v], V_EN[v], V_BASE[v], V_WIN[v],
                    V_ENTRY[v], V_LAT[v], V_HOLD[v]);
        end

        // R1 reset while a fetch is waiting on memory
        @(negedge clk);
        lat_cfg = 50; entry_cfg = 32'h0000_0006; xlate_en = 1'b1;
        tbl_base = 32'h0000_0100; win_start = 32'hFF00_0000;
        req_addr = 32'hFF00_3000; req_write = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "still fetching", mem_req, 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "ready after mid-fetch reset", req_ready, 1);
        check("R1", "fetch dropped by reset", mem_req, 0);
        check("R1", "no response after reset", rsp_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "quiet after release", {mem_req, rsp_valid, flt_strobe}, 3'b000);
        run_vec(V_ADDR[0], V_WR[0], V_EN[0], V_BASE[0], V_WIN[0],
                V_ENTRY[0], 1, 1'b0);

        done = 1;
        finish_run();
    end

endmodule